// File: doc/BRIEF.md
# Serial Receive Buffer with Software Flow Control

This block takes characters arriving on an asynchronous serial line and queues them for a slow consumer. A receiver oversamples the line at sixteen times the bit rate and rebuilds each 8N1 frame. Every good character goes into a deep first-in first-out store. The consumer drains that store through a ready/valid pop port.

The store's fill level also drives a small serial transmitter that runs at the same bit rate. When the queue is close to full, the transmitter sends a stop character back to the sending host. When the queue has drained far enough, it sends a resume character. A host that pastes a long text and obeys these characters cannot overrun the queue.

Two serial inputs are provided so that two connectors can be wired at the same time. Both idle high, and only one is expected to carry traffic at any moment.

Top module: `serial_flow_buffer`

## Requirements
- R1: The receiver decodes 8N1 frames, least significant bit first, at CLK_HZ/BAUD clocks per bit. A start bit is accepted only if the line is still low at its mid-bit sample, so a low pulse shorter than half a bit produces no character.
- R2: A frame whose stop bit samples low is discarded and never reaches the queue. The receiver then waits for the line to return high before it looks for the next start bit.
- R3: When the queue is not empty, popValid is high and popData shows the oldest character. A character is removed on a clock edge where popValid and popReady are both high. Characters leave in arrival order.
- R4: The queue holds DEPTH characters (1000 by default). A character that arrives while the queue is full is dropped and sets overflow, which stays high until reset.
- R5: When occupancy rises to HIGH_MARK (936 by default), the stop character 0x13 is transmitted once.
- R6: After a stop character, the resume character 0x11 is transmitted once when occupancy falls to LOW_MARK (128 by default). No further flow character is sent while occupancy stays between the two marks.
- R7: The transmit line sends 8N1 frames, least significant bit first, at the same bit rate. It carries only the two flow characters and idles high.
- R8: The two serial inputs are combined so that traffic on either one is received while the other idles high.
- R9: After reset, serialOut is high, popValid is low and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serialInA | input | 1 | First serial receive input, idles high |
| serialInB | input | 1 | Second serial receive input, idles high |
| serialOut | output | 1 | Serial transmit line for flow characters |
| popValid | output | 1 | Queue holds at least one character |
| popData | output | 8 | Oldest queued character |
| popReady | input | 1 | Consumer takes popData this cycle |
| overflow | output | 1 | Sticky: a character was dropped because the queue was full |

## Verification
The receive path is driven with the bytes 0x01 and 0x80, which can only be told apart if the bit order is right. The bytes 0x00 and 0xFF are sent on input A, and 0xA5 is sent on input B, which shows that the two inputs are merged. A short low glitch and a frame with a low stop bit must both leave the queue empty, and a good byte sent afterwards must still arrive intact.

A small queue is then filled past its high mark and drained below its low mark twice, once ending in a dropped character. A bench decoder watches the transmit line. It confirms exactly one stop character and one resume character per crossing, none in between, and that the stored order survives the overflow.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam logic [7:0] RESUME_CHAR = 8'h11;
  localparam logic [7:0] PAUSE_CHAR  = 8'h13;
  localparam int         OVS         = 16;

  // strobe from flow control to the transmit datapath
  typedef struct packed {
    logic       load;
    logic [7:0] txChar;
  } flowCmd_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rxState_t;
endpackage

// File: rtl/sfb_rx.sv
module sfb_rx
  import sfb_pkg::*;
#(
  parameter int DIV = 1302
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  output logic       byteValid,
  output logic [7:0] byteData
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [1:0]  syncQ;
  logic        line;
  logic [DW-1:0] divCnt;
  logic        tick;
  rxState_t    state;
  logic [3:0]  tickCnt;
  logic [2:0]  bitIdx;
  logic [7:0]  shiftQ;

  assign line = syncQ[1];
  assign tick = (divCnt == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      divCnt <= '0;
    end else begin
      syncQ  <= {syncQ[0], lineIn};
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      shiftQ    <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!line) begin
            state   <= RX_START;
            tickCnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tickCnt == 4'd7) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= line ? RX_IDLE : RX_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (tickCnt == 4'd15) begin
              tickCnt <= '0;
              shiftQ  <= {line, shiftQ[7:1]};
              if (bitIdx == 3'd7) state <= RX_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (tickCnt == 4'd15) begin
              tickCnt <= '0;
              if (line) begin
                byteValid <= 1'b1;
                byteData  <= shiftQ;
                state     <= RX_IDLE;
              end else begin
                state <= RX_HOLD;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        RX_HOLD: if (line) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(line));
endmodule

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
  parameter int DEPTH = 1000,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic [7:0]    pushData,
  input  logic          popReady,
  output logic          popValid,
  output logic [7:0]    popData,
  output logic [CW-1:0] level,
  output logic          overflow
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          full, doPush, doPop;

  assign full     = (level == CW'(DEPTH));
  assign popValid = (level != '0);
  assign popData  = mem[rdPtr];
  assign doPop    = popReady && popValid;
  assign doPush   = pushValid && !full;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (pushValid && full) overflow <= 1'b1;
    end
  end

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    level <= CW'(DEPTH));
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(overflow));
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && full && !popReady) |=> (level == CW'(DEPTH)) && overflow);
endmodule

// File: rtl/sfb_flowctl.sv
module sfb_flowctl
  import sfb_pkg::*;
#(
  parameter int DEPTH     = 1000,
  parameter int HIGH_MARK = 936,
  parameter int LOW_MARK  = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] level,
  input  logic          txBusy,
  output flowCmd_t      cmd
);
  logic holdOff, pendValid, pendPause;
  logic raiseEvt, dropEvt;

  assign raiseEvt = !holdOff && (level >= CW'(HIGH_MARK));
  assign dropEvt  =  holdOff && (level <= CW'(LOW_MARK));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdOff   <= 1'b0;
      pendValid <= 1'b0;
      pendPause <= 1'b0;
      cmd       <= '0;
    end else begin
      cmd.load <= 1'b0;
      if (raiseEvt) begin
        holdOff   <= 1'b1;
        pendValid <= 1'b1;
        pendPause <= 1'b1;
      end else if (dropEvt) begin
        holdOff   <= 1'b0;
        pendValid <= 1'b1;
        pendPause <= 1'b0;
      end else if (pendValid && !txBusy && !cmd.load) begin
        pendValid  <= 1'b0;
        cmd.load   <= 1'b1;
        cmd.txChar <= pendPause ? PAUSE_CHAR : RESUME_CHAR;
      end
    end
  end

  assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !txBusy);
  assert_flow_char_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> (cmd.txChar == PAUSE_CHAR || cmd.txChar == RESUME_CHAR));
endmodule

// File: rtl/sfb_tx.sv
module sfb_tx
  import sfb_pkg::*;
#(
  parameter int DIV = 1302,
  localparam int BITCLK = DIV * OVS,
  localparam int BW = $clog2(BITCLK)
) (
  input  logic     clk,
  input  logic     rstN,
  input  flowCmd_t cmd,
  output logic     serialOut,
  output logic     busy
);
  logic [BW-1:0] clkCnt;
  logic [3:0]    bitsLeft;
  logic [8:0]    shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serialOut <= 1'b1;
      busy      <= 1'b0;
      clkCnt    <= '0;
      bitsLeft  <= '0;
      shiftQ    <= '1;
    end else if (!busy) begin
      if (cmd.load) begin
        serialOut <= 1'b0;
        shiftQ    <= {1'b1, cmd.txChar};
        bitsLeft  <= 4'd9;
        clkCnt    <= '0;
        busy      <= 1'b1;
      end
    end else if (clkCnt == BW'(BITCLK - 1)) begin
      clkCnt <= '0;
      if (bitsLeft == '0) begin
        busy      <= 1'b0;
        serialOut <= 1'b1;
      end else begin
        serialOut <= shiftQ[0];
        shiftQ    <= {1'b1, shiftQ[8:1]};
        bitsLeft  <= bitsLeft - 1'b1;
      end
    end else begin
      clkCnt <= clkCnt + 1'b1;
    end
  end

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serialOut);
  assert_start_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !serialOut);
endmodule

// File: rtl/serial_flow_buffer.sv
module serial_flow_buffer
  import sfb_pkg::*;
#(
  parameter int CLK_HZ    = 200_000_000,
  parameter int BAUD      = 9600,
  parameter int DEPTH     = 1000,
  parameter int HIGH_MARK = 936,
  parameter int LOW_MARK  = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialInA,
  input  logic       serialInB,
  output logic       serialOut,
  output logic       popValid,
  output logic [7:0] popData,
  input  logic       popReady,
  output logic       overflow
);
  localparam int RAWDIV = CLK_HZ / (BAUD * OVS);
  localparam int DIV    = (RAWDIV < 1) ? 1 : RAWDIV;
  localparam int CW     = $clog2(DEPTH + 1);

  logic          rxValid;
  logic [7:0]    rxData;
  logic [CW-1:0] level;
  logic          txBusy;
  flowCmd_t      cmd;

  // idle-high lines: a wired AND passes whichever one is active
  sfb_rx #(.DIV(DIV)) uRx (
    .clk(clk), .rstN(rstN), .lineIn(serialInA & serialInB),
    .byteValid(rxValid), .byteData(rxData));

  sfb_fifo #(.DEPTH(DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .pushValid(rxValid), .pushData(rxData),
    .popReady(popReady), .popValid(popValid), .popData(popData),
    .level(level), .overflow(overflow));

  sfb_flowctl #(.DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)) uCtl (
    .clk(clk), .rstN(rstN), .level(level), .txBusy(txBusy), .cmd(cmd));

  sfb_tx #(.DIV(DIV)) uTx (
    .clk(clk), .rstN(rstN), .cmd(cmd), .serialOut(serialOut), .busy(txBusy));
endmodule

// File: tb/tb_serial_flow_buffer.sv
module tb_serial_flow_buffer;
  localparam int BITC = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic serialInA = 1'b1, serialInB = 1'b1, popReady = 1'b0;
  logic serialOut, popValid, overflow;
  logic [7:0] popData;
  int tests = 0, fails = 0;
  logic [7:0] txLog [16];
  int txCount = 0;

  always #2.5 clk = ~clk;

  serial_flow_buffer #(.CLK_HZ(200_000_000), .BAUD(6_250_000), .DEPTH(32),
    .HIGH_MARK(24), .LOW_MARK(8)) dut (
    .clk(clk), .rstN(rstN), .serialInA(serialInA), .serialInB(serialInB),
    .serialOut(serialOut), .popValid(popValid), .popData(popData),
    .popReady(popReady), .overflow(overflow));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic driveLine(input logic useB, input logic v);
    if (useB) serialInB = v; else serialInA = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic sendFrame(input logic useB, input logic [7:0] d, input logic stopBit);
    driveLine(useB, 1'b0);
    for (int b = 0; b < 8; b++) driveLine(useB, d[b]);
    driveLine(useB, stopBit);
    if (!stopBit) driveLine(useB, 1'b1);
  endtask

  task automatic popExpect(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(popValid === 1'b1 && popData === exp, req, {popValid, popData}, {1'b1, exp});
    popReady = 1'b1;
    @(negedge clk);
    popReady = 1'b0;
  endtask

  // decoder for the transmit line
  initial begin
    logic [7:0] v;
    forever begin
      @(negedge clk);
      if (rstN && serialOut === 1'b0) begin
        repeat (BITC/2) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
          repeat (BITC) @(negedge clk);
          v[b] = serialOut;
        end
        repeat (BITC) @(negedge clk);
        check(serialOut === 1'b1, "R7 stop bit", serialOut, 1);
        if (txCount < 16) txLog[txCount] = v;
        txCount++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic testReset();
    repeat (4) @(negedge clk);
    check(serialOut === 1'b1, "R9 serialOut", serialOut, 1);
    check(popValid === 1'b0, "R9 popValid", popValid, 0);
    check(overflow === 1'b0, "R9 overflow", overflow, 0);
  endtask

  task automatic testBitOrder();
    sendFrame(1'b0, 8'h01, 1'b1);
    sendFrame(1'b0, 8'h80, 1'b1);
    sendFrame(1'b0, 8'h00, 1'b1);
    sendFrame(1'b0, 8'hFF, 1'b1);
    popExpect(8'h01, "R1 lsb first");
    popExpect(8'h80, "R1 msb");
    popExpect(8'h00, "R3 order zero");
    popExpect(8'hFF, "R3 order ones");
    @(negedge clk);
    check(popValid === 1'b0, "R3 empty", popValid, 0);
  endtask

  task automatic testInputB();
    sendFrame(1'b1, 8'hA5, 1'b1);
    popExpect(8'hA5, "R8 input B");
  endtask

  task automatic testGlitch();
    serialInA = 1'b0;
    repeat (4) @(negedge clk);
    serialInA = 1'b1;
    repeat (3*BITC) @(negedge clk);
    check(popValid === 1'b0, "R1 glitch ignored", popValid, 0);
    sendFrame(1'b0, 8'h3C, 1'b1);
    popExpect(8'h3C, "R1 after glitch");
  endtask

  task automatic testFraming();
    sendFrame(1'b0, 8'h5A, 1'b0);
    repeat (BITC) @(negedge clk);
    check(popValid === 1'b0, "R2 framing discard", popValid, 0);
    sendFrame(1'b0, 8'hC3, 1'b1);
    popExpect(8'hC3, "R2 recovery");
  endtask

  task automatic testWatermarks();
    for (int i = 0; i < 25; i++) sendFrame(1'b0, 8'(8'h40 + i), 1'b1);
    repeat (2*BITC) @(negedge clk);
    check(txCount == 1, "R5 single pause", txCount, 1);
    check(txLog[0] == 8'h13, "R5 pause char", txLog[0], 8'h13);
    for (int i = 0; i < 17; i++) popExpect(8'(8'h40 + i), "R3 drain order");
    repeat (12*BITC) @(negedge clk);
    check(txCount == 2, "R6 single resume", txCount, 2);
    check(txLog[1] == 8'h11, "R6 resume char", txLog[1], 8'h11);
    for (int i = 17; i < 25; i++) popExpect(8'(8'h40 + i), "R3 drain rest");
    repeat (12*BITC) @(negedge clk);
    check(txCount == 2, "R6 no resend below low mark", txCount, 2);
  endtask

  task automatic testOverflow();
    for (int i = 0; i < 32; i++) sendFrame(1'b0, 8'(8'h80 + i), 1'b1);
    check(overflow === 1'b0, "R4 full no overflow", overflow, 0);
    sendFrame(1'b0, 8'hEE, 1'b1);
    check(overflow === 1'b1, "R4 overflow set", overflow, 1);
    check(txCount == 3 && txLog[2] == 8'h13, "R5 second pause", txCount, 3);
    for (int i = 0; i < 32; i++) popExpect(8'(8'h80 + i), "R4 kept bytes");
    @(negedge clk);
    check(popValid === 1'b0, "R4 extra byte dropped", popValid, 0);
    repeat (12*BITC) @(negedge clk);
    check(txCount == 4 && txLog[3] == 8'h11, "R6 second resume", txCount, 4);
    check(overflow === 1'b1, "R4 overflow sticky", overflow, 1);
    check(serialOut === 1'b1, "R7 idle high", serialOut, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBitOrder();
    testInputB();
    testGlitch();
    testFraming();
    testWatermarks();
    testOverflow();
    finishRun();
  end
endmodule